// File: doc/BRIEF.md
# Readout Data Selection Filter

This block sits in the receive path of a pixel-readout chip, after the stage that aligns the serial stream into whole words and before the buffer that feeds a slower host link. The chip sends the memory of every pixel as a fixed-length block of words, pixel after pixel. The link cannot carry the full stream. The filter therefore keeps its own word and pixel counters and forwards only the words that a selection mode picks. It drops all other words.

An acquisition starts with a start pulse. The filter latches the mode and the selection settings and then asks the readout sequencer for a readout cycle. At the end of each readout the sequencer returns a pass-done pulse.

There are three modes:
- **Single-channel mode** keeps one pixel.
- **Window mode** keeps every pixel whose row and column fall inside an inclusive rectangle.
- **Decimated full mode** relies on the chip's non-destructive re-reads. It requests eight readouts of the same data. In pass k it keeps the words whose position inside the pixel block equals k modulo 8. After eight passes every word has been sent exactly once.

Top module: `rsf_readout_filter`

## Requirements
- R1: After reset, `out_valid`, `rd_req`, `acq_done` and `busy` are all low.
- R2: When the block is idle, an `acq_start` with an accepted configuration raises `busy` and pulses `rd_req` for one cycle, both visible one clock after the start. An `acq_start` while `busy` is high is ignored: it gives no `rd_req` and does not change the acquisition in progress.
- R3: Mode code 0 (single) forwards only the words of the pixel whose channel index equals `cfg_channel`. The channel index counts the complete blocks of WORDS words seen since the start of the pass, from 0. It wraps to 0 after ROWS*COLS-1.
- R4: Mode code 1 (full) forwards, in pass k (k = 0 for the first readout), exactly the words whose position inside their pixel block, taken modulo 8, equals k.
- R5: In full mode, a `pass_done` after passes 0 to 6 pulses `rd_req` and advances k by one. A `pass_done` after pass 7 pulses `acq_done` and clears `busy`. Over the eight passes every word is forwarded exactly once.
- R6: Mode code 2 (window) forwards the words of pixels with row = channel / COLS and column = channel mod COLS such that `cfg_row_lo` ≤ row ≤ `cfg_row_hi` and `cfg_col_lo` ≤ column ≤ `cfg_col_hi`.
- R7: The block refuses a start, giving no `rd_req` and leaving `busy` low, in three cases: mode code 3, a window with either low bound above its high bound, or a window covering more than MAX_SEL pixels (ROWS*COLS/8 by default).
- R8: The mode and selection inputs are sampled only on an accepted start. Changes to them during an acquisition have no effect on which words are forwarded.
- R9: In single and window mode, the first `pass_done` ends the acquisition: `acq_done` pulses and `busy` clears one clock later.
- R10: A forwarded word shows on `out_data` with `out_valid` high one clock after it was presented. Words presented while `busy` is low are never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 0 single, 1 full, 2 window, 3 refused |
| cfg_channel | input | log2(ROWS*COLS) | Channel kept in single mode |
| cfg_row_lo | input | log2(ROWS) | Window lowest row, inclusive |
| cfg_row_hi | input | log2(ROWS) | Window highest row, inclusive |
| cfg_col_lo | input | log2(COLS) | Window lowest column, inclusive |
| cfg_col_hi | input | log2(COLS) | Window highest column, inclusive |
| acq_start | input | 1 | Start an acquisition |
| in_valid | input | 1 | Incoming word valid |
| in_data | input | DATA_W | Incoming word |
| pass_done | input | 1 | One readout finished |
| out_valid | output | 1 | Forwarded word valid |
| out_data | output | DATA_W | Forwarded word |
| rd_req | output | 1 | Request one readout cycle |
| acq_done | output | 1 | Acquisition complete |
| busy | output | 1 | Acquisition in progress |

## Verification
The bench runs full mode through all eight passes and counts how often each word was forwarded. A design whose offset fails to advance, wraps early or is off by one sends some words twice and others never.

Single-channel tests include channels 0 and the last channel, and random input gaps stress the counters. A tracker that advances on idle cycles or wraps wrongly picks the wrong pixel.

Windows are drawn at random up to the size limit. Oversized, inverted and reserved-mode starts must be refused, which exposes a design that accepts a 9-pixel window or drops the inclusive bound.

The bench also changes the settings and pulses start in the middle of an acquisition. A design that reads the live inputs instead of the latched copy then changes its selection.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
   typedef enum logic [1:0] {
      SEL_SINGLE = 2'd0,
      SEL_FULL   = 2'd1,
      SEL_WINDOW = 2'd2,
      SEL_NONE   = 2'd3
   } sel_mode_e;
endpackage

// File: rtl/rsf_index_track.sv
module rsf_index_track #(
   parameter int WORDS  = 16,
   parameter int PIXELS = 4096,
   parameter int STRIDE = 8,
   localparam int WI_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int CH_W  = $clog2(PIXELS),
   localparam int SW    = $clog2(STRIDE)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            advance,
   output logic [SW-1:0]   word_lo,
   output logic [CH_W-1:0] chan
);
   localparam logic [WI_W-1:0] LAST_W  = WI_W'(WORDS - 1);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(PIXELS - 1);

   logic [WI_W-1:0] word_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_idx <= '0;
         chan     <= '0;
      end else if (clear) begin
         word_idx <= '0;
         chan     <= '0;
      end else if (advance) begin
         if (word_idx == LAST_W) begin
            word_idx <= '0;
            chan     <= (chan == LAST_CH) ? '0 : chan + 1'b1;
         end else begin
            word_idx <= word_idx + 1'b1;
         end
      end
   end

   assign word_lo = word_idx[SW-1:0];

   // R3: channel wraps to zero after the last pixel block
   a_r3_chan_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && word_idx == LAST_W && chan == LAST_CH) |=> chan == '0);

   // R3: channel index never moves without an accepted word
   a_r3_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !clear) |=> $stable(chan));
endmodule

// File: rtl/rsf_select.sv
module rsf_select
   import rsf_pkg::*;
#(
   parameter int ROWS   = 64,
   parameter int COLS   = 64,
   parameter int STRIDE = 8,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS),
   localparam int CH_W  = ROW_W + COL_W,
   localparam int SW    = $clog2(STRIDE)
) (
   input  sel_mode_e        mode,
   input  logic [CH_W-1:0]  sel_chan,
   input  logic [ROW_W-1:0] row_lo,
   input  logic [ROW_W-1:0] row_hi,
   input  logic [COL_W-1:0] col_lo,
   input  logic [COL_W-1:0] col_hi,
   input  logic [SW-1:0]    offset,
   input  logic [SW-1:0]    word_lo,
   input  logic [CH_W-1:0]  chan,
   output logic             hit
);
   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;
   logic             in_win;

   assign row    = chan[CH_W-1:COL_W];
   assign col    = chan[COL_W-1:0];
   assign in_win = (row >= row_lo) && (row <= row_hi) &&
                   (col >= col_lo) && (col <= col_hi);

   always_comb begin
      unique case (mode)
         SEL_SINGLE: hit = (chan == sel_chan);
         SEL_FULL:   hit = (word_lo == offset);
         SEL_WINDOW: hit = in_win;
         default:    hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/rsf_pass_ctrl.sv
module rsf_pass_ctrl
   import rsf_pkg::*;
#(
   parameter int ROWS    = 64,
   parameter int COLS    = 64,
   parameter int STRIDE  = 8,
   parameter int MAX_SEL = ROWS * COLS / 8,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int CH_W   = ROW_W + COL_W,
   localparam int SW     = $clog2(STRIDE),
   localparam int AREA_W = ROW_W + COL_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [CH_W-1:0]  cfg_channel,
   input  logic [ROW_W-1:0] cfg_row_lo,
   input  logic [ROW_W-1:0] cfg_row_hi,
   input  logic [COL_W-1:0] cfg_col_lo,
   input  logic [COL_W-1:0] cfg_col_hi,
   input  logic             acq_start,
   input  logic             pass_done,
   output sel_mode_e        mode_q,
   output logic [CH_W-1:0]  chan_q,
   output logic [ROW_W-1:0] row_lo_q,
   output logic [ROW_W-1:0] row_hi_q,
   output logic [COL_W-1:0] col_lo_q,
   output logic [COL_W-1:0] col_hi_q,
   output logic [SW-1:0]    offset,
   output logic             busy,
   output logic             rd_req,
   output logic             acq_done,
   output logic             clear_idx
);
   localparam logic [SW-1:0] LAST_OFF = SW'(STRIDE - 1);

   sel_mode_e         mode_in;
   logic [ROW_W:0]    win_h;
   logic [COL_W:0]    win_w;
   logic [AREA_W-1:0] area;
   logic              win_ok, mode_ok, start_ok, pass_end;

   assign mode_in = sel_mode_e'(cfg_mode);
   assign win_h   = {1'b0, cfg_row_hi} - {1'b0, cfg_row_lo} + 1'b1;
   assign win_w   = {1'b0, cfg_col_hi} - {1'b0, cfg_col_lo} + 1'b1;
   assign area    = AREA_W'(win_h) * AREA_W'(win_w);
   assign win_ok  = (cfg_row_lo <= cfg_row_hi) && (cfg_col_lo <= cfg_col_hi) &&
                    (area <= AREA_W'(MAX_SEL));

   always_comb begin
      unique case (mode_in)
         SEL_SINGLE, SEL_FULL: mode_ok = 1'b1;
         SEL_WINDOW:           mode_ok = win_ok;
         default:              mode_ok = 1'b0;
      endcase
   end

   assign start_ok  = acq_start && !busy && mode_ok;
   assign pass_end  = busy && pass_done;
   assign clear_idx = start_ok || pass_end;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         rd_req   <= 1'b0;
         acq_done <= 1'b0;
         offset   <= '0;
         mode_q   <= SEL_NONE;
         chan_q   <= '0;
         row_lo_q <= '0;
         row_hi_q <= '0;
         col_lo_q <= '0;
         col_hi_q <= '0;
      end else begin
         rd_req   <= 1'b0;
         acq_done <= 1'b0;
         if (start_ok) begin
            busy     <= 1'b1;
            rd_req   <= 1'b1;
            offset   <= '0;
            mode_q   <= mode_in;
            chan_q   <= cfg_channel;
            row_lo_q <= cfg_row_lo;
            row_hi_q <= cfg_row_hi;
            col_lo_q <= cfg_col_lo;
            col_hi_q <= cfg_col_hi;
         end else if (pass_end) begin
            if (mode_q == SEL_FULL && offset != LAST_OFF) begin
               offset <= offset + 1'b1;
               rd_req <= 1'b1;
            end else begin
               busy     <= 1'b0;
               acq_done <= 1'b1;
            end
         end
      end
   end

   // R2: a readout request lasts a single cycle
   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R2: a start while busy leaves the offset untouched
   a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && acq_start && !pass_done) |=> ($stable(offset) && !rd_req));

   // R5: each intermediate full-mode pass moves the offset on by one
   a_r5_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pass_done && mode_q == SEL_FULL && offset != LAST_OFF)
      |=> (offset == $past(offset) + 1'b1) && rd_req && busy);

   // R5, R9: completion only ever follows a pass end
   a_r9_done_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
      acq_done |-> ($past(pass_done) && $past(busy) && !busy));

   // R5: completion and request never coincide
   a_r5_req_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req, acq_done}));

   // R7: a refused start leaves the block idle
   a_r7_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_start && !busy && !mode_ok) |=> (!busy && !rd_req));

   // R8: latched settings stay put through an acquisition
   a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(mode_q) && $stable(chan_q) &&
                                 $stable(row_lo_q) && $stable(col_hi_q)));
endmodule

// File: rtl/rsf_readout_filter.sv
module rsf_readout_filter
   import rsf_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ROWS    = 64,
   parameter int COLS    = 64,
   parameter int WORDS   = 16,
   parameter int STRIDE  = 8,
   parameter int MAX_SEL = ROWS * COLS / 8,
   parameter bit OUT_REG = 1'b1,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COL_W  = $clog2(COLS),
   localparam int CH_W   = ROW_W + COL_W,
   localparam int SW     = $clog2(STRIDE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [CH_W-1:0]   cfg_channel,
   input  logic [ROW_W-1:0]  cfg_row_lo,
   input  logic [ROW_W-1:0]  cfg_row_hi,
   input  logic [COL_W-1:0]  cfg_col_lo,
   input  logic [COL_W-1:0]  cfg_col_hi,
   input  logic              acq_start,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              pass_done,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              rd_req,
   output logic              acq_done,
   output logic              busy
);
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (COLS < 2 || (COLS & (COLS - 1)) != 0) begin : g_bad_cols
      $error("COLS must be a power of two of at least 2");
   end
   if (STRIDE < 2 || (STRIDE & (STRIDE - 1)) != 0) begin : g_bad_stride
      $error("STRIDE must be a power of two of at least 2");
   end
   if (WORDS < STRIDE) begin : g_bad_words
      $error("WORDS must be at least STRIDE");
   end
   if (MAX_SEL < 1 || MAX_SEL > ROWS * COLS) begin : g_bad_max
      $error("MAX_SEL out of range");
   end

   sel_mode_e        mode_q;
   logic [CH_W-1:0]  chan_q, chan;
   logic [ROW_W-1:0] row_lo_q, row_hi_q;
   logic [COL_W-1:0] col_lo_q, col_hi_q;
   logic [SW-1:0]    offset, word_lo;
   logic             clear_idx, advance, hit, fwd;

   rsf_pass_ctrl #(
      .ROWS(ROWS), .COLS(COLS), .STRIDE(STRIDE), .MAX_SEL(MAX_SEL)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_mode(cfg_mode), .cfg_channel(cfg_channel),
      .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
      .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi),
      .acq_start(acq_start), .pass_done(pass_done),
      .mode_q(mode_q), .chan_q(chan_q),
      .row_lo_q(row_lo_q), .row_hi_q(row_hi_q),
      .col_lo_q(col_lo_q), .col_hi_q(col_hi_q),
      .offset(offset), .busy(busy), .rd_req(rd_req),
      .acq_done(acq_done), .clear_idx(clear_idx)
   );

   assign advance = in_valid && busy;

   rsf_index_track #(
      .WORDS(WORDS), .PIXELS(ROWS * COLS), .STRIDE(STRIDE)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .clear(clear_idx), .advance(advance),
      .word_lo(word_lo), .chan(chan)
   );

   rsf_select #(
      .ROWS(ROWS), .COLS(COLS), .STRIDE(STRIDE)
   ) u_sel (
      .mode(mode_q), .sel_chan(chan_q),
      .row_lo(row_lo_q), .row_hi(row_hi_q),
      .col_lo(col_lo_q), .col_hi(col_hi_q),
      .offset(offset), .word_lo(word_lo), .chan(chan), .hit(hit)
   );

   assign fwd = advance && hit;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
         end else begin
            out_valid <= fwd;
            if (fwd) out_data <= in_data;
         end
      end

      // R10: every forwarded word was presented one cycle earlier
      a_r10_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> ($past(in_valid) && out_data == $past(in_data)));

      // R10: nothing leaves while idle
      a_r10_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |=> !out_valid);
   end else begin : g_out_comb
      assign out_valid = fwd;
      assign out_data  = in_data;

      // R10: combinational variant forwards only while busy
      a_r10_comb_busy: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> busy);
   end
endmodule

// File: tb/rsf_readout_filter_tb.sv
module rsf_readout_filter_tb;
   localparam int DATA_W  = 16;
   localparam int ROWS    = 8;
   localparam int COLS    = 8;
   localparam int WORDS   = 16;
   localparam int PIX     = ROWS * COLS;
   localparam int MAX_SEL = PIX / 8;
   localparam int CH_W    = $clog2(PIX);
   localparam int ROW_W   = $clog2(ROWS);
   localparam int COL_W   = $clog2(COLS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] cfg_mode = '0;
   logic [CH_W-1:0] cfg_channel = '0;
   logic [ROW_W-1:0] cfg_row_lo = '0, cfg_row_hi = '0;
   logic [COL_W-1:0] cfg_col_lo = '0, cfg_col_hi = '0;
   logic acq_start = 1'b0, in_valid = 1'b0, pass_done = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic out_valid, rd_req, acq_done, busy;
   logic [DATA_W-1:0] out_data;

   always #2.5 clk = ~clk;

   rsf_readout_filter #(
      .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS), .WORDS(WORDS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_channel(cfg_channel),
      .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
      .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi),
      .acq_start(acq_start), .in_valid(in_valid), .in_data(in_data),
      .pass_done(pass_done), .out_valid(out_valid), .out_data(out_data),
      .rd_req(rd_req), .acq_done(acq_done), .busy(busy)
   );

   int n_checks = 0, n_fail = 0;
   bit finished = 1'b0;
   int e_mode, e_chan, e_rlo, e_rhi, e_clo, e_chi, e_off;
   bit e_busy = 1'b0;
   int b_wi, b_ch;
   int fwd_cnt [PIX*WORDS];
   int seed_dummy;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_sel(input int wi, input int ch);
      int row = ch / COLS;
      int col = ch % COLS;
      case (e_mode)
         0: return ch == e_chan;
         1: return (wi % 8) == e_off;
         2: return row >= e_rlo && row <= e_rhi && col >= e_clo && col <= e_chi;
         default: return 1'b0;
      endcase
   endfunction

   // one clock: drive at negedge, check at following negedge
   task automatic cycle(input bit v, input string req);
      bit sel;
      logic [DATA_W-1:0] d = DATA_W'($urandom);
      in_valid = v;
      in_data  = d;
      sel = v && e_busy && exp_sel(b_wi, b_ch);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == sel, req, int'(out_valid), int'(sel));
      if (sel) check(out_data == d, "R10 data", int'(out_data), int'(d));
      if (out_valid && e_mode == 1 && e_busy) fwd_cnt[b_ch*WORDS + b_wi]++;
      if (v && e_busy) begin
         b_wi++;
         if (b_wi == WORDS) begin
            b_wi = 0;
            b_ch = (b_ch + 1) % PIX;
         end
      end
   endtask

   task automatic run_words(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         if ($urandom % 5 == 0) cycle(1'b0, req);
         cycle(1'b1, req);
      end
   endtask

   task automatic do_start(input int m, input bit expect_ok, input string req);
      cfg_mode = 2'(m);
      acq_start = 1'b1;
      @(negedge clk);
      acq_start = 1'b0;
      check(rd_req == expect_ok, req, int'(rd_req), int'(expect_ok));
      check(busy == (expect_ok || e_busy), req, int'(busy), int'(expect_ok || e_busy));
      if (expect_ok && !e_busy) begin
         e_busy = 1'b1;
         e_mode = m;
         e_chan = int'(cfg_channel);
         e_rlo = int'(cfg_row_lo); e_rhi = int'(cfg_row_hi);
         e_clo = int'(cfg_col_lo); e_chi = int'(cfg_col_hi);
         e_off = 0;
         b_wi = 0; b_ch = 0;
      end
   endtask

   task automatic end_pass(input string req);
      bit last;
      last = (e_mode != 1) || (e_off == 7);
      pass_done = 1'b1;
      @(negedge clk);
      pass_done = 1'b0;
      check(rd_req == !last, req, int'(rd_req), int'(!last));
      check(acq_done == last, req, int'(acq_done), int'(last));
      check(busy == !last, req, int'(busy), int'(!last));
      if (last) e_busy = 1'b0; else e_off++;
      b_wi = 0; b_ch = 0;
   endtask

   task automatic scramble_cfg();
      cfg_channel = CH_W'($urandom);
      cfg_row_lo = ROW_W'($urandom); cfg_row_hi = ROW_W'($urandom);
      cfg_col_lo = COL_W'($urandom); cfg_col_hi = COL_W'($urandom);
      cfg_mode = 2'($urandom);
   endtask

   task automatic set_window(input int rl, input int h, input int cl, input int w);
      cfg_row_lo = ROW_W'(rl); cfg_row_hi = ROW_W'(rl + h - 1);
      cfg_col_lo = COL_W'(cl); cfg_col_hi = COL_W'(cl + w - 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      // R1 reset state, checked while reset is held
      check(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
      check(rd_req == 0, "R1 rd_req", int'(rd_req), 0);
      check(acq_done == 0, "R1 acq_done", int'(acq_done), 0);
      check(busy == 0, "R1 busy", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: words while idle are dropped
      run_words(20, "R10 idle drop");

      // R7: reserved mode, inverted and oversized windows refused
      do_start(3, 1'b0, "R7 reserved mode");
      set_window(2, 1, 5, 1); cfg_row_hi = 3'd1;
      do_start(2, 1'b0, "R7 inverted window");
      set_window(0, 3, 0, 3);
      do_start(2, 1'b0, "R7 oversize window");

      // R3, R9: single channel, corners and random
      for (int t = 0; t < 4; t++) begin
         cfg_channel = (t == 0) ? '0 : (t == 1) ? CH_W'(PIX - 1) : CH_W'($urandom);
         do_start(0, 1'b1, "R2 start single");
         scramble_cfg();  // R8: live changes ignored
         run_words(PIX * WORDS, "R3 single select");
         end_pass("R9 single end");
      end

      // R3: channel wraps when more words arrive than one pass holds
      cfg_channel = CH_W'(1);
      do_start(0, 1'b1, "R2 start wrap");
      run_words(PIX * WORDS + 2 * WORDS, "R3 channel wrap");
      end_pass("R9 wrap end");

      // R6, R9: random windows within the size limit, incl. full-width strip
      for (int t = 0; t < 4; t++) begin
         int h, w;
         h = (t == 0) ? 1 : 1 + int'($urandom % 3);
         w = (t == 0) ? MAX_SEL : 1 + int'($urandom % (MAX_SEL / h));
         set_window(int'($urandom % (ROWS - h + 1)), h,
                    int'($urandom % (COLS - w + 1)), w);
         do_start(2, 1'b1, "R2 start window");
         scramble_cfg();  // R8
         run_words(PIX * WORDS, "R6 window select");
         end_pass("R9 window end");
      end

      // R4, R5: eight full passes, every word once
      foreach (fwd_cnt[i]) fwd_cnt[i] = 0;
      do_start(1, 1'b1, "R2 start full");
      for (int p = 0; p < 8; p++) begin
         scramble_cfg();  // R8
         if (p == 3) begin
            // R2: start while busy is ignored
            cfg_mode = 2'd0;
            acq_start = 1'b1;
            @(negedge clk);
            acq_start = 1'b0;
            check(rd_req == 0, "R2 busy start ignored", int'(rd_req), 0);
            check(busy == 1, "R2 busy kept", int'(busy), 1);
         end
         run_words(PIX * WORDS, "R4 full stride");
         end_pass("R5 pass step");
      end
      for (int i = 0; i < PIX * WORDS; i++)
         if (fwd_cnt[i] != 1) check(1'b0, "R5 word coverage", fwd_cnt[i], 1);
      check(1'b1, "R5 coverage done", 1, 1);

      run_words(10, "R10 idle after done");

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule